// File: doc/BRIEF.md
# Multi-mode 16-bit capture/PWM timer

This block is one 16-bit down-counting timer channel. One counter serves five behaviours: one-shot timing, periodic timing, counting edges on a capture pin, timestamping edges on that pin, and PWM generation. A small word-wide register port sets the behaviour, the active edge, the output polarity, a debug stall and an ADC trigger gate. The same port writes the reload and compare values and reads back the counter and the last captured value.

Software writes the configuration, the reload value and the compare value first. It then sets the enable bit, and the counter loads the reload value on the edge that takes the write. The channel reports through two sticky flags, one for timeout and one for capture or match. Software clears a flag by writing a one to its status bit. A one-cycle ADC trigger pulse and a PWM pin are driven straight from the counter state.

Top module: `cap_pwm_timer`

## Requirements
- R1: After reset every register reads 0 and every output is 0. Reads return 0 in all bits that are not defined. In the configuration word at address 0, only bits 3:0 are stored. In the control word at address 1, only bits 5:0 are stored.
- R2: The configuration word holds the behaviour field in bits 1:0, the capture-type bit in bit 2 and the alternate bit in bit 3. When the behaviour field is 0, or when the alternate bit is set in any combination other than capture-type 0 with behaviour field 2, the counter holds the reload value, no flag is raised and the PWM pin stays at the inversion level.
- R3: Periodic mode (behaviour field 2, alternate 0) with reload L raises a timeout L+1 cycles after the enabling write and every L+1 cycles after that, reloading L each time.
- R4: One-shot mode (behaviour field 1) raises exactly one timeout L+1 cycles after enabling. It then clears the enable bit (control bit 0) by itself and leaves the counter at 0.
- R5: The ADC trigger output is a one-cycle pulse in the cycle the timeout flag is set, and only when the trigger enable bit (control bit 4) is 1.
- R6: With the stall bit (control bit 1) set, the counter is frozen while the debug-halt input is high. With the stall bit clear, the counter keeps counting whatever that input is.
- R7: Clearing the enable bit freezes the counter at its present value.
- R8: Edge-count mode (behaviour field 3, capture-type 0) decrements the counter once per selected edge. When the new value equals the compare value, the event flag is set, the enable bit clears and later edges have no effect.
- R9: The event field in control bits 3:2 selects the active pin edge: 0 rising, 1 falling, 3 both, and 2 no edges at all.
- R10: Edge-time mode (behaviour field 3, capture-type 1) runs the counter down every cycle and wraps it to the reload value at 0. A selected pin edge sets the event flag and latches into the capture register (address 5) the counter value that was current two cycles after the pin changed.
- R11: PWM mode (alternate 1, capture-type 0, behaviour field 2) reloads like periodic mode. The pin is high while the counter is above the compare value, so it is high for L-M of every L+1 cycles (0 if M>=L). When the inversion bit (control bit 5) is 1, the pin level is inverted.
- R12: Status bit 0 (timeout) and status bit 1 (event) at address 6 are sticky and drive the two flag outputs. Writing a 1 to a status bit clears it. Addresses: 2 reload, 3 compare, 4 counter (read only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |
| cap_pin | input | 1 | Asynchronous capture pin |
| dbg_halt | input | 1 | Debug halt request |
| pwm_out | output | 1 | PWM pin |
| adc_trig | output | 1 | One-cycle ADC trigger pulse |
| tmo_flag | output | 1 | Sticky timeout flag |
| evt_flag | output | 1 | Sticky capture/match flag |

## Verification
A register write takes effect on the clock edge that samples it. The counter holds the reload value right after that edge, and a timeout flag or ADC pulse becomes visible L+1 edges later. A pin change needs two synchronizer edges plus one action edge, so a capture or edge-count result shows up on the third edge after the change. The bench drives every input and samples every output on the falling clock edge. It counts falling edges from the enabling write and checks capture values against a counter read taken in the same half-cycle as the pin change. Results are compared only once their full latency has passed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int AW = 3;

  localparam logic [AW-1:0] A_MODE   = 3'd0;
  localparam logic [AW-1:0] A_CTRL   = 3'd1;
  localparam logic [AW-1:0] A_LOAD   = 3'd2;
  localparam logic [AW-1:0] A_MATCH  = 3'd3;
  localparam logic [AW-1:0] A_COUNT  = 3'd4;
  localparam logic [AW-1:0] A_CAPT   = 3'd5;
  localparam logic [AW-1:0] A_STATUS = 3'd6;

  typedef enum logic [2:0] {
    BEH_NONE     = 3'd0,
    BEH_ONESHOT  = 3'd1,
    BEH_PERIODIC = 3'd2,
    BEH_EDGECNT  = 3'd3,
    BEH_EDGETIME = 3'd4,
    BEH_PWM      = 3'd5
  } beh_e;

  // Mode field, capture-type bit and alternate bit to one behaviour.
  function automatic beh_e decode_beh(input logic [1:0] mode, input logic ctype,
                                      input logic alt);
    beh_e b;
    b = BEH_NONE;
    if (alt) begin
      if (!ctype && mode == 2'd2) b = BEH_PWM;
    end else begin
      case (mode)
        2'd1:    b = BEH_ONESHOT;
        2'd2:    b = BEH_PERIODIC;
        2'd3:    b = ctype ? BEH_EDGETIME : BEH_EDGECNT;
        default: b = BEH_NONE;
      endcase
    end
    return b;
  endfunction

  // Edge selection: 0 rising, 1 falling, 2 none, 3 both.
  function automatic logic edge_sel(input logic [1:0] ev, input logic rise,
                                    input logic fall);
    logic e;
    case (ev)
      2'd0:    e = rise;
      2'd1:    e = fall;
      2'd3:    e = rise | fall;
      default: e = 1'b0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  // stage[0..STAGES-1] synchronize, stage[STAGES] holds the previous level
  logic [STAGES:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= 1'b0;
    else        stage[0] <= pin;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[i] <= 1'b0;
      else        stage[i] <= stage[i-1];
    end
  end

  assign rise =  stage[STAGES-1] & ~stage[STAGES];
  assign fall = ~stage[STAGES-1] &  stage[STAGES];

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] capt,
  input  logic          tmo_set,
  input  logic          evt_set,
  input  logic          self_clr,
  output logic [1:0]    mode,
  output logic          ctype,
  output logic          alt,
  output logic          en,
  output logic          stall_en,
  output logic [1:0]    ev,
  output logic          trig_en,
  output logic          inv,
  output logic [CW-1:0] load_val,
  output logic [CW-1:0] match_val,
  output logic          start,
  output logic          tmo_flag,
  output logic          evt_flag
);

  logic wr_mode, wr_ctrl, wr_stat;

  assign wr_mode = wr_en && (wr_addr == A_MODE);
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_stat = wr_en && (wr_addr == A_STATUS);
  assign start   = wr_ctrl && wr_data[0] && !en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0; ctype <= 1'b0; alt <= 1'b0;
      stall_en <= 1'b0; ev <= '0; trig_en <= 1'b0; inv <= 1'b0;
      load_val <= '0; match_val <= '0;
    end else if (wr_en) begin
      if (wr_mode) begin
        mode <= wr_data[1:0]; ctype <= wr_data[2]; alt <= wr_data[3];
      end
      if (wr_ctrl) begin
        stall_en <= wr_data[1]; ev <= wr_data[3:2];
        trig_en <= wr_data[4]; inv <= wr_data[5];
      end
      if (wr_addr == A_LOAD)  load_val  <= wr_data;
      if (wr_addr == A_MATCH) match_val <= wr_data;
    end
  end

  // enable: a software write wins over the self-clear from the core
  always_ff @(posedge clk) begin
    if (!rst_n)        en <= 1'b0;
    else if (wr_ctrl)  en <= wr_data[0];
    else if (self_clr) en <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_flag <= 1'b0;
      evt_flag <= 1'b0;
    end else begin
      tmo_flag <= tmo_set | (tmo_flag & ~(wr_stat & wr_data[0]));
      evt_flag <= evt_set | (evt_flag & ~(wr_stat & wr_data[1]));
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_MODE:   begin rd_data[1:0] = mode; rd_data[2] = ctype; rd_data[3] = alt; end
      A_CTRL:   begin
        rd_data[0] = en; rd_data[1] = stall_en; rd_data[3:2] = ev;
        rd_data[4] = trig_en; rd_data[5] = inv;
      end
      A_LOAD:   rd_data = load_val;
      A_MATCH:  rd_data = match_val;
      A_COUNT:  rd_data = cnt;
      A_CAPT:   rd_data = capt;
      A_STATUS: begin rd_data[0] = tmo_flag; rd_data[1] = evt_flag; end
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  beh_e          beh,
  input  logic          en,
  input  logic          start,
  input  logic          run_ok,
  input  logic          edge_evt,
  input  logic          trig_en,
  input  logic          inv,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] match_val,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] capt,
  output logic          tmo_evt,
  output logic          match_hit,
  output logic          cap_evt,
  output logic          self_clr,
  output logic          adc_trig,
  output logic          pwm_out
);

  localparam logic [CW-1:0] ONE = CW'(1);

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
    return v - ONE;
  endfunction

  function automatic logic above(input logic [CW-1:0] v, input logic [CW-1:0] m);
    return v > m;
  endfunction

  logic [CW-1:0] cnt_nxt;
  logic          is_timer;

  assign is_timer = (beh == BEH_ONESHOT) || (beh == BEH_PERIODIC) || (beh == BEH_PWM);

  always_comb begin
    cnt_nxt   = cnt;
    tmo_evt   = 1'b0;
    match_hit = 1'b0;
    if (start) begin
      cnt_nxt = load_val;
    end else if (en && run_ok) begin
      if (is_timer) begin
        if (cnt == '0) begin
          tmo_evt = 1'b1;
          cnt_nxt = (beh == BEH_ONESHOT) ? '0 : load_val;
        end else begin
          cnt_nxt = dec(cnt);
        end
      end else if (beh == BEH_EDGECNT) begin
        if (edge_evt) begin
          cnt_nxt   = dec(cnt);
          match_hit = (dec(cnt) == match_val);
        end
      end else if (beh == BEH_EDGETIME) begin
        cnt_nxt = (cnt == '0) ? load_val : dec(cnt);
      end
    end
  end

  // capture is not held off by the stall: only the count freezes
  assign cap_evt  = en && !start && (beh == BEH_EDGETIME) && edge_evt;
  assign self_clr = (tmo_evt && beh == BEH_ONESHOT) || match_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      capt     <= '0;
      adc_trig <= 1'b0;
    end else begin
      cnt      <= cnt_nxt;
      adc_trig <= tmo_evt & trig_en;
      if (cap_evt) capt <= cnt;
    end
  end

  assign pwm_out = inv ^ (en && (beh == BEH_PWM) && above(cnt, match_val));

endmodule

// File: rtl/cap_pwm_timer.sv
module cap_pwm_timer
  import tmr_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic          cap_pin,
  input  logic          dbg_halt,
  output logic          pwm_out,
  output logic          adc_trig,
  output logic          tmo_flag,
  output logic          evt_flag
);

  logic [1:0]    mode;
  logic          ctype, alt, en, stall_en, trig_en, inv, start;
  logic [1:0]    ev;
  logic [CW-1:0] load_val, match_val, cnt, capt;
  logic          pin_rise, pin_fall;

  // named internal events, also used by the bound checker
  beh_e beh;
  logic edge_evt, stall_now, run_ok;
  logic tmo_evt, match_hit, cap_evt, self_clr;

  assign beh       = decode_beh(mode, ctype, alt);
  assign edge_evt  = edge_sel(ev, pin_rise, pin_fall);
  assign stall_now = stall_en && dbg_halt;
  assign run_ok    = !stall_now;

  tmr_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt(cnt), .capt(capt),
    .tmo_set(tmo_evt), .evt_set(match_hit | cap_evt), .self_clr(self_clr),
    .mode(mode), .ctype(ctype), .alt(alt), .en(en), .stall_en(stall_en), .ev(ev),
    .trig_en(trig_en), .inv(inv), .load_val(load_val), .match_val(match_val),
    .start(start), .tmo_flag(tmo_flag), .evt_flag(evt_flag)
  );

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise(pin_rise), .fall(pin_fall)
  );

  tmr_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .beh(beh), .en(en), .start(start), .run_ok(run_ok),
    .edge_evt(edge_evt), .trig_en(trig_en), .inv(inv), .load_val(load_val),
    .match_val(match_val), .cnt(cnt), .capt(capt), .tmo_evt(tmo_evt),
    .match_hit(match_hit), .cap_evt(cap_evt), .self_clr(self_clr),
    .adc_trig(adc_trig), .pwm_out(pwm_out)
  );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          en,
  input beh_e          beh,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] capt,
  input logic          tmo_evt,
  input logic          match_hit,
  input logic          cap_evt,
  input logic          stall_now,
  input logic          adc_trig,
  input logic          tmo_flag,
  input logic          evt_flag
);

  p_trig_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> tmo_flag);

  p_tmo_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(cnt) == '0);

  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt && beh == BEH_ONESHOT && !wr_en) |=> !en);

  p_match_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_hit && !wr_en) |=> (!en && evt_flag));

  p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !wr_en) |=> (capt == $past(cnt) && evt_flag));

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_now && !wr_en) |=> $stable(cnt));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> $stable(cnt));

endmodule

bind cap_pwm_timer tmr_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .en(en), .beh(beh), .cnt(cnt),
  .capt(capt), .tmo_evt(tmo_evt), .match_hit(match_hit), .cap_evt(cap_evt),
  .stall_now(stall_now), .adc_trig(adc_trig), .tmo_flag(tmo_flag),
  .evt_flag(evt_flag)
);

// File: tb/cap_pwm_timer_tb.sv
module cap_pwm_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        cap_pin = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        pwm_out, adc_trig, tmo_flag, evt_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  cap_pwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap_pin(cap_pin), .dbg_halt(dbg_halt),
    .pwm_out(pwm_out), .adc_trig(adc_trig), .tmo_flag(tmo_flag), .evt_flag(evt_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    rd_addr = a;
    #1;
    d = int'(rd_data);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cap_pin = 1'b0; dbg_halt = 1'b0; wr_en = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic pulse();
    cap_pin = 1'b1; step(4);
    cap_pin = 1'b0; step(4);
  endtask

  // negedges after the enabling write until adc_trig is first high
  task automatic first_trig(output int k);
    k = -1;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (adc_trig) begin k = i; break; end
    end
  endtask

  task automatic count_trig(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      highs += int'(adc_trig);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v, v2, k, h;
    int ls[6] = '{0, 1, 2, 3, 5, 9};
    int gaps[5] = '{2, 5, 9, 14, 3};

    // R1: reset values and undefined bits
    do_reset();
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk($sformatf("R1 reset read addr %0d", a), v, 0);
    end
    chk("R1 reset outputs", int'({pwm_out, adc_trig, tmo_flag, evt_flag}), 0);
    wr(3'd0, 16'hFFFF); rd(3'd0, v); chk("R1 config undefined bits", v, 16'h000F);
    wr(3'd1, 16'hFFFE); rd(3'd1, v); chk("R1 control undefined bits", v, 16'h003E);

    // R3 / R5: periodic timeouts and trigger spacing
    foreach (ls[i]) begin
      do_reset();
      wr(3'd0, 16'd2); wr(3'd2, 16'(ls[i])); wr(3'd1, 16'h0011);
      first_trig(k);
      chk($sformatf("R3 first timeout L=%0d", ls[i]), k, ls[i] + 1);
      count_trig(3 * (ls[i] + 1), h);
      chk($sformatf("R5 pulses in 3 periods L=%0d", ls[i]), h, 3);
    end

    // R4 / R12: one-shot
    do_reset();
    wr(3'd0, 16'd1); wr(3'd2, 16'd4); wr(3'd1, 16'h0011);
    first_trig(k); chk("R4 one-shot timeout cycle", k, 5);
    count_trig(20, h); chk("R4 no second timeout", h, 0);
    rd(3'd1, v); chk("R4 enable self-cleared", v, 16'h0010);
    rd(3'd4, v); chk("R4 counter rests at 0", v, 0);
    chk("R12 timeout flag sticky", int'(tmo_flag), 1);
    wr(3'd6, 16'h0001); chk("R12 write-1 clears timeout", int'(tmo_flag), 0);

    // R5: trigger gated off
    do_reset();
    wr(3'd0, 16'd2); wr(3'd2, 16'd3); wr(3'd1, 16'h0001);
    count_trig(20, h); chk("R5 no trigger when gate off", h, 0);
    chk("R5 timeout still flagged", int'(tmo_flag), 1);

    // R2: idle behaviours
    do_reset();
    wr(3'd0, 16'd0); wr(3'd2, 16'd5); wr(3'd1, 16'h0011);
    count_trig(20, h); chk("R2 mode 0 no trigger", h, 0);
    rd(3'd4, v); chk("R2 mode 0 counter holds", v, 5);
    chk("R2 mode 0 no flag", int'(tmo_flag), 0);
    do_reset();
    wr(3'd0, 16'd14); wr(3'd2, 16'd5); wr(3'd3, 16'd1); wr(3'd1, 16'h0011);
    step(20);
    rd(3'd4, v); chk("R2 bad alternate combo counter holds", v, 5);
    chk("R2 bad alternate combo pwm low", int'(pwm_out), 0);

    // R6: stall
    do_reset();
    dbg_halt = 1'b1;
    wr(3'd0, 16'd2); wr(3'd2, 16'd100); wr(3'd1, 16'h0003);
    rd(3'd4, v); chk("R6 frozen at load", v, 100);
    step(10); rd(3'd4, v); chk("R6 frozen while halted", v, 100);
    wr(3'd1, 16'h0001);
    rd(3'd4, v); step(10); rd(3'd4, v2);
    chk("R6 counts when stall off", v - v2, 10);
    dbg_halt = 1'b0;

    // R7: disable freezes
    do_reset();
    wr(3'd0, 16'd2); wr(3'd2, 16'd100); wr(3'd1, 16'h0001);
    step(5); wr(3'd1, 16'h0000);
    rd(3'd4, v); step(10); rd(3'd4, v2);
    chk("R7 counter frozen when disabled", v2, v);

    // R8: edge count to match
    do_reset();
    wr(3'd0, 16'd3); wr(3'd2, 16'd10); wr(3'd3, 16'd6); wr(3'd1, 16'h0001);
    pulse(); pulse(); pulse();
    rd(3'd4, v); chk("R8 three edges counted", v, 7);
    chk("R8 no flag before match", int'(evt_flag), 0);
    pulse();
    rd(3'd4, v); chk("R8 value at match", v, 6);
    chk("R8 flag at match", int'(evt_flag), 1);
    rd(3'd1, v); chk("R8 enable cleared at match", v & 1, 0);
    pulse();
    rd(3'd4, v); chk("R8 edges ignored after match", v, 6);

    // R9: edge selection
    do_reset();
    wr(3'd0, 16'd3); wr(3'd2, 16'd10); wr(3'd3, 16'd0); wr(3'd1, 16'h0005);
    cap_pin = 1'b1; step(4); rd(3'd4, v); chk("R9 falling: rise ignored", v, 10);
    cap_pin = 1'b0; step(4); rd(3'd4, v); chk("R9 falling: fall counted", v, 9);
    wr(3'd1, 16'h000D);
    cap_pin = 1'b1; step(4); rd(3'd4, v); chk("R9 both: rise counted", v, 8);
    cap_pin = 1'b0; step(4); rd(3'd4, v); chk("R9 both: fall counted", v, 7);
    wr(3'd1, 16'h0009);
    pulse(); pulse(); rd(3'd4, v); chk("R9 code 2 selects nothing", v, 7);

    // R10: edge-time capture
    do_reset();
    wr(3'd0, 16'd7); wr(3'd2, 16'd1000); wr(3'd1, 16'h0001);
    foreach (gaps[i]) begin
      step(gaps[i]);
      rd(3'd4, v);
      cap_pin = 1'b1;
      step(6);
      rd(3'd5, v2); chk($sformatf("R10 capture value gap %0d", gaps[i]), v2, v - 2);
      chk("R10 event flag on capture", int'(evt_flag), 1);
      wr(3'd6, 16'h0002);
      cap_pin = 1'b0;
      step(6);
      rd(3'd5, v); chk("R10 unselected edge keeps capture", v, v2);
    end

    // R11: PWM duty and inversion
    for (int iv = 0; iv < 2; iv++) begin
      for (int m = 0; m <= 8; m++) begin
        int exp_h;
        do_reset();
        wr(3'd0, 16'd10); wr(3'd2, 16'd7); wr(3'd3, 16'(m));
        wr(3'd1, 16'(1 | (iv << 5)));
        step(3);
        h = 0;
        for (int s = 0; s < 8; s++) begin
          @(negedge clk);
          h += int'(pwm_out);
        end
        exp_h = (m < 7) ? 7 - m : 0;
        if (iv == 1) exp_h = 8 - exp_h;
        chk($sformatf("R11 pwm highs M=%0d inv=%0d", m, iv), h, exp_h);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule